// File: doc/BRIEF.md
# Grouped-interrupt general-purpose port

This block is a general-purpose port of parameterised width (32 pins by default). Each pin is set as an input or an output by a direction register. For an input pin, a per-pin polarity bit can invert the level before it is stored. A single value register holds both the driven levels of the output pins and the sampled, polarity-corrected levels of the input pins. Software changes output pins through a plain value write or through atomic set and clear writes. None of these three writes can touch a pin that is configured as an input.

A rising edge on a corrected input latches its bit in a cause register. If that pin is also enabled in the mask register, the rising edge raises one of four summary lines to an upstream interrupt aggregator. Each summary line covers one byte group of pins.

A single mode bit, kept in a control register, selects how a summary line falls again:
- **Edge mode:** software writes the cause register, and the write clears the group's summary when it leaves that group's cause byte at zero.
- **Level mode:** a falling input clears the group's summary when it leaves that group's value byte at zero.

The register bus is a simple single-cycle bus. Writes take effect at the clock edge where the write strobe is high. Read data follows the address combinationally.

Top module: `gpio_grp_irq`

## Requirements
- R1: After reset, the direction, polarity, value, cause, mask and mode state are all 0, and every summary line is low.
- R2: A direction bit of 1 makes the pin an output. The three writes to output pins behave as follows, and none of them changes a bit whose direction is 0:
  - A write to address 2 (value) loads the output bits from the write data.
  - A write to address 3 (set) ORs the write data into the output bits.
  - A write to address 4 (clear) clears the output bits where the write data has a 1.
  - `pin_out` always equals the value register.
- R3: Reads of address 3 and address 4 return 0. So does a read of any address above 8.
- R4: At each clock edge, the value bit of an input pin (direction 0) is loaded with the pin level XOR its polarity bit. The polarity register is at address 1, and a 1 inverts the pin. The value register reads at address 2.
- R5: A 0-to-1 change of the stored, polarity-corrected value of an input pin sets that pin's bit in the cause register, which is at address 5.
- R6: When a pin whose mask bit is 1 rises as in R5, summary line `irq_sum[n/8]` is high from the same clock edge. This assertion takes priority over any deassertion in the same cycle.
- R7: Write data bit 10 at address 8 sets the mode bit (0 = edge, 1 = level). A read of address 8 returns 0x11FF0000 with the mode bit placed at bit 10.
- R8: Edge mode behaves as follows:
  - A write to address 5 loads the cause register from the write data, and any new rising edge in that cycle is ORed in.
  - A summary line falls when such a write has an all-zero byte for its group.
  - Falling inputs have no effect on the summaries.
- R9: Level mode behaves as follows:
  - A summary line falls when an input of its group falls and that group's value byte becomes all zero.
  - Cause writes do not lower a summary line.
- R10: Addresses 6 and 7 both read and write the same mask register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| pin_in | input | 32 | Pin levels, assumed synchronous to `clk` |
| pin_out | output | 32 | Value register, which drives the output pins |
| irq_sum | output | 4 | Per-byte-group interrupt summary lines |

## Verification
The bench builds the block with its default parameters: 32 pins in byte groups, giving four summary lines and a 4-bit address.

This width exercises each of the following:
- A mixed direction pattern in which the low byte is driven and the upper bytes are sampled.
- A polarity-inverted pin that produces a rising edge purely from a register write.
- Masked and unmasked pins in two different groups.

It also reaches both deassertion rules:
- A partial cause clear that leaves a group's summary high, followed by a full clear that lowers it.
- A level-mode group whose summary stays high while a second pin of the group is still high, and falls only when the last pin drops.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
  localparam int REG_ADDR_W = 4;

  localparam logic [REG_ADDR_W-1:0] A_DIR      = 4'd0;
  localparam logic [REG_ADDR_W-1:0] A_POL      = 4'd1;
  localparam logic [REG_ADDR_W-1:0] A_VAL      = 4'd2;
  localparam logic [REG_ADDR_W-1:0] A_SET      = 4'd3;
  localparam logic [REG_ADDR_W-1:0] A_CLR      = 4'd4;
  localparam logic [REG_ADDR_W-1:0] A_CAUSE    = 4'd5;
  localparam logic [REG_ADDR_W-1:0] A_MASK     = 4'd6;
  localparam logic [REG_ADDR_W-1:0] A_MASK_ALT = 4'd7;
  localparam logic [REG_ADDR_W-1:0] A_CTRL     = 4'd8;

  localparam logic [31:0] CTRL_RD_BASE = 32'h11FF_0000;
  localparam int          MODE_BIT     = 10;
endpackage

// File: rtl/gpio_grp_regs.sv
module gpio_grp_regs
  import gpio_grp_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  value_q,
  input  logic [NPINS-1:0]  cause_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  mask_q,
  output logic              mode_q,
  output logic              wr_val,
  output logic              wr_set,
  output logic              wr_clr,
  output logic              wr_cause,
  output logic [NPINS-1:0]  rdata
);
  logic wr_dir, wr_pol, wr_mask, wr_ctrl;
  logic [NPINS-1:0] dir_d, pol_d, mask_d;
  logic mode_d;

  // address decode
  always_comb begin
    wr_dir   = wr_en && (addr == A_DIR);
    wr_pol   = wr_en && (addr == A_POL);
    wr_val   = wr_en && (addr == A_VAL);
    wr_set   = wr_en && (addr == A_SET);
    wr_clr   = wr_en && (addr == A_CLR);
    wr_cause = wr_en && (addr == A_CAUSE);
    wr_mask  = wr_en && ((addr == A_MASK) || (addr == A_MASK_ALT));
    wr_ctrl  = wr_en && (addr == A_CTRL);
  end

  // next-state
  always_comb begin
    dir_d  = wr_dir  ? wdata : dir_q;
    pol_d  = wr_pol  ? wdata : pol_q;
    mask_d = wr_mask ? wdata : mask_q;
    mode_d = wr_ctrl ? wdata[MODE_BIT] : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      pol_q  <= '0;
      mask_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (wr_dir)  dir_q  <= dir_d;
      if (wr_pol)  pol_q  <= pol_d;
      if (wr_mask) mask_q <= mask_d;
      if (wr_ctrl) mode_q <= mode_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      A_DIR:                rdata = dir_q;
      A_POL:                rdata = pol_q;
      A_VAL:                rdata = value_q;
      A_CAUSE:              rdata = cause_q;
      A_MASK, A_MASK_ALT:   rdata = mask_q;
      A_CTRL: begin
        rdata = NPINS'(CTRL_RD_BASE);
        rdata[MODE_BIT] = mode_q;
      end
      default:              rdata = '0;
    endcase
  end

  // R10: either mask address lands in the shared mask
  p_mask_alias_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_MASK_ALT)) |=> (mask_q == $past(wdata)));

  // R3: set and clear addresses read as zero
  p_setclr_rd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr == A_SET) || (addr == A_CLR)) |-> (rdata == '0));

  // R7: mode bit follows a control write
  p_mode_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_CTRL)) |=> (mode_q == $past(wdata[MODE_BIT])));
endmodule

// File: rtl/gpio_grp_core.sv
module gpio_grp_core #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] pol_q,
  input  logic             wr_val,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_cause,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] value_q,
  output logic [NPINS-1:0] value_d,
  output logic [NPINS-1:0] cause_q,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  logic [NPINS-1:0] in_eff, out_d, cause_d;
  logic cause_en;
  logic seen_q;

  always_comb begin
    in_eff = pin_in ^ pol_q;
    rise   = in_eff & ~value_q & ~dir_q;
    fall   = ~in_eff & value_q & ~dir_q;
    if (wr_val)      out_d = wdata;
    else if (wr_set) out_d = value_q | wdata;
    else if (wr_clr) out_d = value_q & ~wdata;
    else             out_d = value_q;
    value_d  = (out_d & dir_q) | (in_eff & ~dir_q);
    cause_d  = (wr_cause ? wdata : cause_q) | rise;
    cause_en = wr_cause || (|rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      cause_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      value_q <= value_d;
      seen_q  <= 1'b1;
      if (cause_en) cause_q <= cause_d;
    end
  end

  // R4: input bits carry the corrected pin level of the previous cycle
  p_input_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((value_q & ~$past(dir_q)) ==
                (($past(pin_in) ^ $past(pol_q)) & ~$past(dir_q))));

  // R2: output bits hold unless a value, set or clear write happened
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(wr_val) && !$past(wr_set) && !$past(wr_clr)) |->
      ((value_q & $past(dir_q)) == ($past(value_q) & $past(dir_q))));

  // R5: every detected rise lands in the cause register
  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((cause_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/gpio_grp_summary.sv
module gpio_grp_summary #(
  parameter int NPINS = 32,
  parameter int GRP_W = 8,
  localparam int NGRP = NPINS / GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] rise,
  input  logic [NPINS-1:0] fall,
  input  logic [NPINS-1:0] mask_q,
  input  logic [NPINS-1:0] value_d,
  input  logic             mode_q,
  input  logic             wr_cause,
  input  logic [NPINS-1:0] wdata,
  output logic [NGRP-1:0]  sum_q
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic set_g, clr_edge, clr_lvl, sum_d, sum_en;

    always_comb begin
      set_g    = |(rise[g*GRP_W +: GRP_W] & mask_q[g*GRP_W +: GRP_W]);
      clr_edge = !mode_q && wr_cause && (wdata[g*GRP_W +: GRP_W] == '0);
      clr_lvl  = mode_q && (|fall[g*GRP_W +: GRP_W]) &&
                 (value_d[g*GRP_W +: GRP_W] == '0);
      sum_en   = set_g || clr_edge || clr_lvl;
      sum_d    = set_g;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum_q[g] <= 1'b0;
      else if (sum_en) sum_q[g] <= sum_d;
    end

    // R6: a masked rise raises this group's line
    p_masked_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise[g*GRP_W +: GRP_W] & mask_q[g*GRP_W +: GRP_W])) |=> sum_q[g]);

    // R8: in edge mode only a cause write may lower the line
    p_edge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_q[g] && !mode_q && !wr_cause) |=> sum_q[g]);

    // R9: in level mode only a falling input may lower the line
    p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_q[g] && mode_q && !(|fall[g*GRP_W +: GRP_W])) |=> sum_q[g]);
  end
endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq
  import gpio_grp_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int GRP_W  = 8,
  parameter int ADDR_W = REG_ADDR_W,
  localparam int NGRP  = NPINS / GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NGRP-1:0]   irq_sum
);
  logic rst_meta_q, rst_sync_n;
  logic [NPINS-1:0] dir_q, pol_q, mask_q, value_q, value_d, cause_q, rise, fall;
  logic mode_q, wr_val, wr_set, wr_clr, wr_cause;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  gpio_grp_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .value_q(value_q), .cause_q(cause_q),
    .dir_q(dir_q), .pol_q(pol_q), .mask_q(mask_q), .mode_q(mode_q),
    .wr_val(wr_val), .wr_set(wr_set), .wr_clr(wr_clr), .wr_cause(wr_cause),
    .rdata(bus_rdata)
  );

  gpio_grp_core #(.NPINS(NPINS)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .pin_in(pin_in), .dir_q(dir_q),
    .pol_q(pol_q), .wr_val(wr_val), .wr_set(wr_set), .wr_clr(wr_clr),
    .wr_cause(wr_cause), .wdata(bus_wdata), .value_q(value_q),
    .value_d(value_d), .cause_q(cause_q), .rise(rise), .fall(fall)
  );

  gpio_grp_summary #(.NPINS(NPINS), .GRP_W(GRP_W)) u_sum (
    .clk(clk), .rst_n(rst_sync_n), .rise(rise), .fall(fall),
    .mask_q(mask_q), .value_d(value_d), .mode_q(mode_q),
    .wr_cause(wr_cause), .wdata(bus_wdata), .sum_q(irq_sum)
  );

  assign pin_out = value_q;

  // R1: summaries are low while reset is held
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (irq_sum == '0));
endmodule

// File: tb/gpio_grp_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_grp_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [3:0]  irq_sum;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int          kind;   // 0 register read, 1 summary, 2 pin_out
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  gpio_grp_irq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq_sum(irq_sum)
  );

  // monitor: pops expected items and compares with the design
  initial begin
    forever begin
      sb_item_t it;
      logic [31:0] act;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {28'd0, irq_sum};
        default: act = pin_out;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(int k, logic [31:0] e, string t);
    sb_item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
    #0.5;
  endtask

  task automatic exp_reg(logic [3:0] a, logic [31:0] e, string t);
    bus_addr = a;
    #0.5;
    push(0, e, t);
  endtask

  task automatic exp_sum(logic [3:0] e, string t);
    push(1, {28'd0, e}, t);
  endtask

  task automatic exp_out(logic [31:0] e, string t);
    push(2, e, t);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_pins(logic [31:0] p);
    @(negedge clk);
    pin_in = p;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, R7 control read
    exp_reg(4'd0, 32'h0, "R1 dir reset");
    exp_reg(4'd2, 32'h0, "R1 value reset");
    exp_reg(4'd5, 32'h0, "R1 cause reset");
    exp_reg(4'd6, 32'h0, "R1 mask reset");
    exp_reg(4'd8, 32'h11FF_0000, "R7 ctrl reset read");
    exp_sum(4'b0000, "R1 summaries reset");

    // R2 output writes touch only output pins
    wr(4'd0, 32'h0000_00FF);
    wr(4'd2, 32'hFFFF_FFA5);
    exp_reg(4'd2, 32'h0000_00A5, "R2 value write");
    exp_out(32'h0000_00A5, "R2 pin_out");
    wr(4'd3, 32'h0000_0F0A);
    exp_reg(4'd2, 32'h0000_00AF, "R2 set write");
    exp_reg(4'd3, 32'h0, "R3 set reads zero");
    wr(4'd4, 32'hF000_00F0);
    exp_reg(4'd2, 32'h0000_000F, "R2 clear write");
    exp_reg(4'd4, 32'h0, "R3 clear reads zero");
    exp_reg(4'd15, 32'h0, "R3 unmapped reads zero");

    // R4 polarity inversion, R5 rise from inversion
    wr(4'd1, 32'h0000_0100);
    @(negedge clk);
    exp_reg(4'd2, 32'h0000_010F, "R4 inverted input");
    exp_reg(4'd5, 32'h0000_0100, "R5 cause from inversion");
    exp_sum(4'b0000, "R6 unmasked rise no summary");
    wr(4'd5, 32'h0);
    exp_reg(4'd5, 32'h0, "R8 cause write");

    // R10 mask alias
    wr(4'd7, 32'h0100_0200);
    exp_reg(4'd6, 32'h0100_0200, "R10 mask alias read");

    // R6 masked rise on pin 9
    set_pins(32'h0000_0200);
    exp_sum(4'b0010, "R6 group1 summary");
    exp_reg(4'd5, 32'h0000_0200, "R5 cause pin9");
    exp_reg(4'd2, 32'h0000_030F, "R4 value pin9");
    set_pins(32'h0000_0600);
    exp_reg(4'd5, 32'h0000_0600, "R5 cause pin10");
    set_pins(32'h0000_0400);
    exp_sum(4'b0010, "R8 edge mode fall keeps summary");
    wr(4'd5, 32'h0000_0400);
    exp_sum(4'b0010, "R8 partial cause clear keeps summary");
    wr(4'd5, 32'h0);
    exp_sum(4'b0000, "R8 full cause clear lowers summary");

    // R6 group3 via pin 24
    set_pins(32'h0100_0400);
    exp_sum(4'b1000, "R6 group3 summary");
    exp_reg(4'd5, 32'h0100_0000, "R5 cause pin24");

    // R9 level mode
    wr(4'd8, 32'h0000_0400);
    exp_reg(4'd8, 32'h11FF_0400, "R7 ctrl level read");
    wr(4'd5, 32'h0);
    exp_sum(4'b1000, "R9 cause write keeps summary");
    set_pins(32'h0300_0400);
    set_pins(32'h0200_0400);
    exp_sum(4'b1000, "R9 group byte nonzero keeps summary");
    set_pins(32'h0000_0400);
    exp_sum(4'b0000, "R9 group byte zero lowers summary");
    exp_reg(4'd5, 32'h0200_0000, "R5 cause pin25");
    exp_out(32'h0000_050F, "R2 pin_out final");

    wait (sb_q.size() == 0);
    #1;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule